// File: doc/BRIEF.md
# Open-Drain Line Direction Arbiter

This block joins pairs of open-drain data lines, one on the host side and one on the card side, and works out at run time which way data flows across each pair. Nothing tells it the direction: whichever line is seen going low first while the pair is at rest becomes the input, and the block pulls the opposite line low so that it follows. When the input line goes high again, the block lets go and the pair is back at rest, ready for either side to start the next bit.

A reception enable from the activation sequencer gates the whole block. While it is low, every card-side line is held low and every host-side line is left released. Each line is passed through a synchroniser before edge detection. The channel count is a parameter, and the default of three covers the main data line plus two auxiliary lines. Each channel decides its direction on its own.

Top module: `odl_dir_arb`

## Requirements
- R1: In reset, and while `rx_en` is low, every channel has `card_pull`=1 (card line pulled low) and `host_pull`=0 (host line released).
- R2: One clock edge after `rx_en` is sampled high, every channel is neutral, with `host_pull`=0 and `card_pull`=0.
- R3: In the neutral state, a falling edge on the host line while the card line reads high makes the host the input, and the block drives `card_pull`=1 with `host_pull`=0.
- R4: In the neutral state, a falling edge on the card line while the host line reads high makes the card the input, and the block drives `host_pull`=1 with `card_pull`=0.
- R5: When the input line rises, both pulls drop to 0. The channel then stays neutral even though the released line rises later through the synchroniser.
- R6: If both lines fall in the same sampled cycle while the channel is neutral, neither side takes ownership and both pulls stay 0.
- R7: While one side owns the channel, edges on the other line have no effect on the pulls.
- R8: With the default two-stage synchroniser, a line edge that arrives just after a falling clock edge changes the pull outputs on the third rising clock edge, and not before.
- R9: When `rx_en` is sampled low, every channel is back in the state of R1 one clock edge later, whatever its ownership was.
- R10: The channels are independent. Ownership of one channel does not change the pulls of any other channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Reception enable from the sequencer |
| host_line | input | N_CH | Sampled host-side line levels |
| card_line | input | N_CH | Sampled card-side line levels |
| host_pull | output | N_CH | 1 = pull the host-side line low |
| card_pull | output | N_CH | 1 = pull the card-side line low |

## Verification
The hardest situation to reach is the return to neutral after a win.

When the block releases the follower line, that line rises several cycles after the input line. A design that looks at levels rather than edges would then take ownership by mistake in the opposite direction.

The bench models each pair as a real wired-AND, combining the bench's own pull with the block's pull. This means the delayed rise comes from the design's own outputs and is not scripted. The bench then checks for several cycles after each release that the pulls stay at 0. Two further cases need cycle-exact alignment of stimulus at a falling clock edge: the case where both sides fall in the same cycle, and the latency check.

// File: rtl/odl_pkg.sv
package odl_pkg;
  typedef enum logic [1:0] {
    ODL_OFF     = 2'd0,
    ODL_IDLE    = 2'd1,
    ODL_HOST_IN = 2'd2,
    ODL_CARD_IN = 2'd3
  } odl_state_e;
endpackage

// File: rtl/odl_sync.sv
module odl_sync #(
  parameter int W        = 3,
  parameter int STAGES   = 2,
  parameter bit RST_HIGH = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int TOTAL = STAGES * W;
  logic [TOTAL-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh <= RST_HIGH ? '1 : '0;
        else     sh <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sh <= RST_HIGH ? '1 : '0;
        else     sh <= {sh[TOTAL-W-1:0], d};
      end
    end
  endgenerate

  assign q = sh[TOTAL-1 -: W];
endmodule

// File: rtl/odl_chan.sv
module odl_chan
  import odl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic h_s,
  input  logic c_s,
  output logic host_pull,
  output logic card_pull
);
  logic       h_d, c_d;
  logic       h_fall, c_fall;
  odl_state_e st, st_nx;

  // Previous synchronised level, used for edge detection.
  always_ff @(posedge clk) begin
    if (rst) begin
      h_d <= 1'b1;
      c_d <= 1'b1;
    end else begin
      h_d <= h_s;
      c_d <= c_s;
    end
  end

  assign h_fall = h_d & ~h_s;
  assign c_fall = c_d & ~c_s;

  always_comb begin
    st_nx = st;
    if (!en) begin
      st_nx = ODL_OFF;
    end else begin
      case (st)
        ODL_OFF:     st_nx = ODL_IDLE;
        ODL_IDLE: begin
          if (h_fall && c_s)      st_nx = ODL_HOST_IN;
          else if (c_fall && h_s) st_nx = ODL_CARD_IN;
        end
        ODL_HOST_IN: if (h_s) st_nx = ODL_IDLE;
        ODL_CARD_IN: if (c_s) st_nx = ODL_IDLE;
        default:     st_nx = ODL_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ODL_OFF;
      card_pull <= 1'b1;
      host_pull <= 1'b0;
    end else begin
      st        <= st_nx;
      card_pull <= (st_nx == ODL_OFF) || (st_nx == ODL_HOST_IN);
      host_pull <= (st_nx == ODL_CARD_IN);
    end
  end

  AST_DISABLED_CARD_LOW: assert property (@(posedge clk) disable iff (rst)
    !en |=> (card_pull && !host_pull)); // R9
  AST_ONE_SIDE_ONLY: assert property (@(posedge clk) disable iff (rst)
    !(card_pull && host_pull)); // R3
  AST_HOST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (en && st == ODL_HOST_IN && !h_s) |=> card_pull); // R7
  AST_HOST_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (en && st == ODL_HOST_IN && h_s) |=> (!card_pull && !host_pull)); // R5
  AST_TIE_NEUTRAL: assert property (@(posedge clk) disable iff (rst)
    (en && st == ODL_IDLE && h_fall && c_fall) |=> (!card_pull && !host_pull)); // R6
endmodule

// File: rtl/odl_dir_arb.sv
module odl_dir_arb #(
  parameter int N_CH        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rx_en,
  input  logic [N_CH-1:0] host_line,
  input  logic [N_CH-1:0] card_line,
  output logic [N_CH-1:0] host_pull,
  output logic [N_CH-1:0] card_pull
);
  logic [N_CH-1:0] h_s, c_s;

  odl_sync #(.W(N_CH), .STAGES(SYNC_STAGES), .RST_HIGH(1'b1)) u_sync_h (
    .clk(clk), .rst(rst), .d(host_line), .q(h_s));
  odl_sync #(.W(N_CH), .STAGES(SYNC_STAGES), .RST_HIGH(1'b1)) u_sync_c (
    .clk(clk), .rst(rst), .d(card_line), .q(c_s));

  genvar i;
  generate
    for (i = 0; i < N_CH; i++) begin : g_ch
      odl_chan u_chan (
        .clk(clk), .rst(rst), .en(rx_en),
        .h_s(h_s[i]), .c_s(c_s[i]),
        .host_pull(host_pull[i]), .card_pull(card_pull[i]));
    end
  endgenerate

  AST_ENABLE_NEUTRAL: assert property (@(posedge clk) disable iff (rst)
    (rx_en && !$past(rx_en) && !$past(rst)) |-> (host_pull == '0)); // R2
endmodule

// File: tb/odl_dir_arb_bench.sv
module odl_dir_arb_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_en = 1'b0;
  logic [N-1:0] host_ext = '0, card_ext = '0;
  logic [N-1:0] host_pull, card_pull, host_line, card_line;

  // Wired-AND open-drain model: the line is low when either side pulls it.
  assign host_line = ~(host_ext | host_pull);
  assign card_line = ~(card_ext | card_pull);

  always #(CLK_PERIOD/2) clk = ~clk;

  odl_dir_arb #(.N_CH(N), .SYNC_STAGES(2)) u_odl_dir_arb (
    .clk(clk), .rst(rst), .rx_en(rx_en),
    .host_line(host_line), .card_line(card_line),
    .host_pull(host_pull), .card_pull(card_pull));

  int n_cmp = 0, n_bad = 0;
  logic [2*N-1:0] q_exp[$];
  string          q_tag[$];
  event           chk_ev;
  bit             done = 0;

  // Monitor: pops expected items and compares against the outputs.
  initial forever begin
    @(chk_ev);
    begin
      logic [2*N-1:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      n_cmp++;
      if ({host_pull, card_pull} !== e) begin
        n_bad++;
        $display("FAIL %s: actual host_pull=%b card_pull=%b expected host_pull=%b card_pull=%b",
                 t, host_pull, card_pull, e[2*N-1:N], e[N-1:0]);
      end
    end
  end

  task automatic expect_now(input logic [N-1:0] eh, input logic [N-1:0] ec, input string tag);
    q_exp.push_back({eh, ec});
    q_tag.push_back(tag);
    ->chk_ev;
    #1;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    expect_now(3'b000, 3'b111, "R1 in reset");
    rst = 1'b0;
    cyc(4);
    expect_now(3'b000, 3'b111, "R1 disabled after reset");

    rx_en = 1'b1;
    cyc(1);
    expect_now(3'b000, 3'b000, "R2 neutral after enable");
    cyc(5);
    expect_now(3'b000, 3'b000, "R2 stays neutral");

    // R8 latency and R3 host win on channel 0
    host_ext[0] = 1'b1;
    cyc(2);
    expect_now(3'b000, 3'b000, "R8 no change before third edge");
    cyc(1);
    expect_now(3'b000, 3'b001, "R8 R3 host wins ch0 on third edge");
    cyc(3);
    expect_now(3'b000, 3'b001, "R3 host win held");

    // R7 card-side activity ignored
    card_ext[0] = 1'b1;
    cyc(4);
    expect_now(3'b000, 3'b001, "R7 card pull ignored while host owns");
    card_ext[0] = 1'b0;
    cyc(4);
    expect_now(3'b000, 3'b001, "R7 card release ignored while host owns");

    // R5 release
    host_ext[0] = 1'b0;
    cyc(3);
    expect_now(3'b000, 3'b000, "R5 neutral after host rises");
    cyc(8);
    expect_now(3'b000, 3'b000, "R5 no false capture after release");

    // R4 card win on channel 1
    card_ext[1] = 1'b1;
    cyc(3);
    expect_now(3'b010, 3'b000, "R4 card wins ch1");
    host_ext[1] = 1'b1;
    cyc(4);
    host_ext[1] = 1'b0;
    cyc(4);
    expect_now(3'b010, 3'b000, "R7 host toggle ignored while card owns");
    card_ext[1] = 1'b0;
    cyc(3);
    expect_now(3'b000, 3'b000, "R5 neutral after card rises");
    cyc(8);
    expect_now(3'b000, 3'b000, "R5 stays neutral after card release");

    // R6 simultaneous fall on channel 2
    host_ext[2] = 1'b1;
    card_ext[2] = 1'b1;
    cyc(6);
    expect_now(3'b000, 3'b000, "R6 tie takes no ownership");
    card_ext[2] = 1'b0;
    cyc(5);
    expect_now(3'b000, 3'b000, "R6 still neutral after one side lifts");
    host_ext[2] = 1'b0;
    cyc(5);
    expect_now(3'b000, 3'b000, "R6 neutral after both lift");

    // R10 independent channels
    host_ext[0] = 1'b1;
    card_ext[2] = 1'b1;
    cyc(4);
    expect_now(3'b100, 3'b001, "R10 ch0 host and ch2 card owned together");
    host_ext[0] = 1'b0;
    cyc(4);
    expect_now(3'b100, 3'b000, "R10 ch0 release leaves ch2 owned");

    // R9 drop enable mid-ownership
    host_ext[1] = 1'b1;
    cyc(4);
    expect_now(3'b100, 3'b010, "R10 ch1 host win beside ch2 card win");
    rx_en = 1'b0;
    cyc(1);
    expect_now(3'b000, 3'b111, "R9 disable forces card low");
    host_ext = '0;
    card_ext = '0;
    cyc(4);
    expect_now(3'b000, 3'b111, "R1 held while disabled");
    rx_en = 1'b1;
    cyc(1);
    expect_now(3'b000, 3'b000, "R2 neutral after re-enable");
    cyc(6);
    expect_now(3'b000, 3'b000, "R5 no capture from card line recovery");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule